// File: doc/BRIEF.md
# PHY Control-Register Access Bridge

This block lets a host processor reach the 16-bit internal control-register space of a PHY through a few scratch registers on a simple 32-bit register bus. On the PHY side it drives a parallel handshake port: one data bus towards the PHY, one data bus back from it, and four strobes (capture address, capture data, read, write), each paired with its own acknowledge.

Software never sends an address and a value together. It loads a shared staging register, then fires a self-clearing trigger that tells the PHY to latch the staged word either as the address or as the data. A read or a write is then fired as a separate trigger. Each trigger reads back as 1 while its operation is in flight, and software polls it until it reads 0. A write therefore takes three triggered steps: capture address, capture data, write. A read takes two: capture address, then read. After the read step clears, the result can be read from a read-only result register. Per-lane PHY registers sit 0x100 apart in the 16-bit space, so the staging register carries full 16-bit addresses.

Only one operation can be in flight. A trigger that arrives while another operation is busy is dropped and leaves a sticky collision flag. A strobe that is never acknowledged is withdrawn after a configurable number of cycles, and this leaves a sticky timeout flag.

Top module: `phycr_bridge`

## Requirements
- R1: After reset, every trigger register, the result register and the status register read 0, and all four PHY strobes are low.
- R2: Register map on the host byte address: 0x3C staging (32-bit read/write); 0x40 result (read-only, 16-bit value in bits 15:0, upper bits 0); 0x44 capture-address trigger; 0x48 capture-data trigger; 0x4C read trigger; 0x50 write trigger; 0x54 status. Any other address reads 0.
- R3: The PHY data bus always carries bits 15:0 of the staging register.
- R4: A host write with bit 0 = 1 to a trigger register, while no operation is busy, raises the matching strobe on the next cycle, and that trigger reads 1 while the strobe is high. A write with bit 0 = 0 starts nothing.
- R5: At most one strobe is high at any time. A strobe stays high until its own acknowledge is sampled. Acknowledges of the other kinds are ignored.
- R6: The cycle after the matching acknowledge is sampled, the strobe is low and the trigger reads 0. A PHY that acknowledges L cycles after first seeing the strobe therefore sees a strobe L+2 cycles long.
- R7: The PHY return bus is captured into the result register on the cycle the read acknowledge is sampled. The result holds until the next read completes. Host writes to 0x40 and other operations leave it unchanged.
- R8: A trigger written while an operation is busy is ignored: no strobe changes. It sets status bit 0 (collision), which stays set until the host writes 1 to bit 0 of the status register.
- R9: A strobe still unacknowledged after WD_CYCLES cycles is dropped, the trigger reads 0, and status bit 1 (timeout) sets until the host writes 1 to status bit 1. A read that times out leaves the result register unchanged.
- R10: The capture-address, capture-data and write sequence stores a value at a 16-bit PHY address, and the capture-address and read sequence returns it. Addresses 0x100 apart stay distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | HOST_AW (8) | Host byte address |
| host_wdata | input | HOST_DW (32) | Host write data |
| host_rdata | output | HOST_DW (32) | Read data for host_addr (combinational) |
| cr_din | output | CR_W (16) | Staged word towards the PHY |
| cr_dout | input | CR_W (16) | Read data returned by the PHY |
| cr_cap_addr_stb | output | 1 | Capture-address strobe |
| cr_cap_data_stb | output | 1 | Capture-data strobe |
| cr_rd_stb | output | 1 | Read strobe |
| cr_wr_stb | output | 1 | Write strobe |
| cr_cap_addr_ack | input | 1 | Capture-address acknowledge |
| cr_cap_data_ack | input | 1 | Capture-data acknowledge |
| cr_rd_ack | input | 1 | Read acknowledge |
| cr_wr_ack | input | 1 | Write acknowledge |

## Verification
A wrong busy flag or operation code is visible at once: a strobe appears on the wrong line, or two lines are high together, or a trigger stays at 1 when it should read 0. Each of these shows within a cycle of the trigger write or of the acknowledge. A watchdog counter that is off by one shows as a timeout strobe one cycle too long or too short, so the bench measures strobe lengths exactly. A result register that captures at the wrong moment shows on the next host read of 0x40, either as a stale value or as data taken from a strobe of another kind.

// File: rtl/phycr_pkg.sv
package phycr_pkg;

  // Host byte offsets. Software decodes these, so they are fixed.
  localparam int unsigned OFF_STAGE  = 'h3C;
  localparam int unsigned OFF_RESULT = 'h40;
  localparam int unsigned OFF_T_CAPA = 'h44;
  localparam int unsigned OFF_T_CAPD = 'h48;
  localparam int unsigned OFF_T_RD   = 'h4C;
  localparam int unsigned OFF_T_WR   = 'h50;
  localparam int unsigned OFF_STATUS = 'h54;

  localparam int unsigned NUM_OPS = 4;

  // Operation code doubles as the index into strobe/ack vectors.
  typedef enum logic [1:0] {
    OP_CAPA  = 2'd0,
    OP_CAPD  = 2'd1,
    OP_READ  = 2'd2,
    OP_WRITE = 2'd3
  } cr_op_e;

  typedef struct packed {
    logic   vld;
    cr_op_e op;
  } trig_req_t;

endpackage

// File: rtl/phycr_rst_sync.sv
module phycr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/phycr_wdog.sv
module phycr_wdog #(
  parameter int unsigned LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);

  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  // Counts cycles spent running; cleared whenever idle.
  always_comb begin
    if (run) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // Fires during the last allowed cycle of a run.
  assign expire = run && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/phycr_seq.sv
module phycr_seq
  import phycr_pkg::*;
#(
  parameter int unsigned WD_CYCLES = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  trig_req_t           trig_req,
  input  logic [NUM_OPS-1:0]  ack,
  output logic [NUM_OPS-1:0]  stb,
  output logic                busy,
  output cr_op_e              cur_op,
  output logic                rd_done,
  output logic                collide,
  output logic                tmo_evt
);

  logic   busy_q, busy_d;
  cr_op_e op_q, op_d;
  logic   op_en;
  logic   start, ack_match, expire, finish;
  logic [1:0] op_bits;

  assign op_bits = op_q;

  phycr_wdog #(.LIMIT(WD_CYCLES)) u_wdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy_q),
    .expire (expire)
  );

  always_comb begin
    start     = trig_req.vld && !busy_q;
    collide   = trig_req.vld && busy_q;
    ack_match = busy_q && ack[op_bits];
    finish    = ack_match || expire;
    tmo_evt   = expire && !ack_match;
    rd_done   = ack_match && (op_q == OP_READ);

    op_en = start;
    op_d  = trig_req.op;

    busy_d = busy_q;
    if (start) begin
      busy_d = 1'b1;
    end else if (finish) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_CAPA;
    end else begin
      busy_q <= busy_d;
      if (op_en) begin
        op_q <= op_d;
      end
    end
  end

  // One strobe line per operation, high while that operation is busy.
  for (genvar g = 0; g < NUM_OPS; g++) begin : g_stb
    localparam logic [1:0] OPC = 2'(g);
    assign stb[g] = busy_q && (op_bits == OPC);
  end

  assign busy   = busy_q;
  assign cur_op = op_q;

endmodule

// File: rtl/phycr_regfile.sv
module phycr_regfile
  import phycr_pkg::*;
#(
  parameter int unsigned AW  = 8,
  parameter int unsigned DW  = 32,
  parameter int unsigned CRW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_wr_en,
  input  logic [AW-1:0]   host_addr,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  output trig_req_t       trig_req,
  output logic [CRW-1:0]  stage_lo,
  input  logic            busy,
  input  cr_op_e          cur_op,
  input  logic            rd_done,
  input  logic [CRW-1:0]  rd_value,
  input  logic            collide,
  input  logic            tmo_evt,
  output logic [CRW-1:0]  result_q,
  output logic            sts_err,
  output logic            sts_tmo
);

  logic hit_stage, hit_result, hit_capa, hit_capd, hit_rd, hit_wr, hit_sts;
  logic hit_trig;

  logic [DW-1:0]  stage_q, stage_d;
  logic           stage_en;
  logic [CRW-1:0] result_d;
  logic           result_en;
  logic           err_q, err_d, tmo_q, tmo_d;
  logic           sts_wr;

  always_comb begin
    hit_stage  = host_addr == AW'(OFF_STAGE);
    hit_result = host_addr == AW'(OFF_RESULT);
    hit_capa   = host_addr == AW'(OFF_T_CAPA);
    hit_capd   = host_addr == AW'(OFF_T_CAPD);
    hit_rd     = host_addr == AW'(OFF_T_RD);
    hit_wr     = host_addr == AW'(OFF_T_WR);
    hit_sts    = host_addr == AW'(OFF_STATUS);
    hit_trig   = hit_capa || hit_capd || hit_rd || hit_wr;
  end

  // Trigger decode: only bit 0 of the written word starts anything.
  always_comb begin
    trig_req.vld = host_wr_en && host_wdata[0] && hit_trig;
    if (hit_capd) begin
      trig_req.op = OP_CAPD;
    end else if (hit_rd) begin
      trig_req.op = OP_READ;
    end else if (hit_wr) begin
      trig_req.op = OP_WRITE;
    end else begin
      trig_req.op = OP_CAPA;
    end
  end

  // Next-state for stored registers.
  always_comb begin
    stage_en  = host_wr_en && hit_stage;
    stage_d   = host_wdata;
    result_en = rd_done;
    result_d  = rd_value;
    sts_wr    = host_wr_en && hit_sts;
    err_d     = collide || (err_q && !(sts_wr && host_wdata[0]));
    tmo_d     = tmo_evt || (tmo_q && !(sts_wr && host_wdata[1]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      result_q <= '0;
      err_q    <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      if (stage_en) begin
        stage_q <= stage_d;
      end
      if (result_en) begin
        result_q <= result_d;
      end
      err_q <= err_d;
      tmo_q <= tmo_d;
    end
  end

  // Host readback.
  always_comb begin
    host_rdata = '0;
    if (hit_stage) begin
      host_rdata = stage_q;
    end else if (hit_result) begin
      host_rdata = {{(DW-CRW){1'b0}}, result_q};
    end else if (hit_capa) begin
      host_rdata = {{(DW-1){1'b0}}, busy && (cur_op == OP_CAPA)};
    end else if (hit_capd) begin
      host_rdata = {{(DW-1){1'b0}}, busy && (cur_op == OP_CAPD)};
    end else if (hit_rd) begin
      host_rdata = {{(DW-1){1'b0}}, busy && (cur_op == OP_READ)};
    end else if (hit_wr) begin
      host_rdata = {{(DW-1){1'b0}}, busy && (cur_op == OP_WRITE)};
    end else if (hit_sts) begin
      host_rdata = {{(DW-2){1'b0}}, tmo_q, err_q};
    end
  end

  assign stage_lo = stage_q[CRW-1:0];
  assign sts_err  = err_q;
  assign sts_tmo  = tmo_q;

endmodule

// File: rtl/phycr_bridge.sv
module phycr_bridge
  import phycr_pkg::*;
#(
  parameter int unsigned HOST_AW   = 8,
  parameter int unsigned HOST_DW   = 32,
  parameter int unsigned CR_W      = 16,
  parameter int unsigned WD_CYCLES = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr_en,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  output logic [CR_W-1:0]    cr_din,
  input  logic [CR_W-1:0]    cr_dout,
  output logic               cr_cap_addr_stb,
  output logic               cr_cap_data_stb,
  output logic               cr_rd_stb,
  output logic               cr_wr_stb,
  input  logic               cr_cap_addr_ack,
  input  logic               cr_cap_data_ack,
  input  logic               cr_rd_ack,
  input  logic               cr_wr_ack
);

  logic                rst_sync_n;
  trig_req_t           trig_req;
  logic [NUM_OPS-1:0]  cr_stb;
  logic [NUM_OPS-1:0]  cr_ack;
  logic                busy;
  cr_op_e              cur_op;
  logic                rd_done;
  logic                collide;
  logic                tmo_evt;
  logic [CR_W-1:0]     result_q;
  logic                sts_err;
  logic                sts_tmo;

  // Vector index follows the operation code.
  assign cr_ack = {cr_wr_ack, cr_rd_ack, cr_cap_data_ack, cr_cap_addr_ack};

  phycr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  phycr_regfile #(.AW(HOST_AW), .DW(HOST_DW), .CRW(CR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .host_wr_en (host_wr_en),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .trig_req   (trig_req),
    .stage_lo   (cr_din),
    .busy       (busy),
    .cur_op     (cur_op),
    .rd_done    (rd_done),
    .rd_value   (cr_dout),
    .collide    (collide),
    .tmo_evt    (tmo_evt),
    .result_q   (result_q),
    .sts_err    (sts_err),
    .sts_tmo    (sts_tmo)
  );

  phycr_seq #(.WD_CYCLES(WD_CYCLES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .trig_req (trig_req),
    .ack      (cr_ack),
    .stb      (cr_stb),
    .busy     (busy),
    .cur_op   (cur_op),
    .rd_done  (rd_done),
    .collide  (collide),
    .tmo_evt  (tmo_evt)
  );

  assign cr_cap_addr_stb = cr_stb[OP_CAPA];
  assign cr_cap_data_stb = cr_stb[OP_CAPD];
  assign cr_rd_stb       = cr_stb[OP_READ];
  assign cr_wr_stb       = cr_stb[OP_WRITE];

endmodule

// File: rtl/phycr_bridge_chk.sv
module phycr_bridge_chk
  import phycr_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned CRW       = 16,
  parameter int unsigned WD_CYCLES = 1024
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_wr_en,
  input logic [AW-1:0]      host_addr,
  input logic               wbit0,
  input logic [NUM_OPS-1:0] stb,
  input logic [NUM_OPS-1:0] ack,
  input logic [CRW-1:0]     phy_dout,
  input logic [CRW-1:0]     result_q,
  input logic               sts_err,
  input logic               tmo_evt
);

  localparam int unsigned CW = $clog2(WD_CYCLES + 2);

  logic [NUM_OPS-1:0] trig_hit;
  logic               trig_wr;
  logic [CW-1:0]      hi_cnt;

  assign trig_hit = {host_addr == AW'(OFF_T_WR), host_addr == AW'(OFF_T_RD),
                     host_addr == AW'(OFF_T_CAPD), host_addr == AW'(OFF_T_CAPA)};
  assign trig_wr  = host_wr_en && wbit0 && (|trig_hit);

  // Length of the current strobe, in cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
    end else if (|stb) begin
      if (hi_cnt != CW'(WD_CYCLES + 1)) begin
        hi_cnt <= hi_cnt + 1'b1;
      end
    end else begin
      hi_cnt <= '0;
    end
  end

  // R4
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr && (stb == '0)) |=> (stb == $past(trig_hit)));

  // R5
  one_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|stb) && !(|(stb & ack)) && !tmo_evt) |=> (stb == $past(stb)));

  // R6
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stb & ack)) |=> (stb == '0));

  // R7
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb[OP_READ] && ack[OP_READ]) |=> (result_q == $past(phy_dout)));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb[OP_READ] && ack[OP_READ]) |=> $stable(result_q));

  // R8
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr && (|stb)) |=> (sts_err && $stable(stb)));

  // R9
  wd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cnt <= CW'(WD_CYCLES));

  // R9
  tmo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> (stb == '0));

endmodule

bind phycr_bridge phycr_bridge_chk #(
  .AW(HOST_AW), .CRW(CR_W), .WD_CYCLES(WD_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .host_wr_en (host_wr_en),
  .host_addr  (host_addr),
  .wbit0      (host_wdata[0]),
  .stb        (cr_stb),
  .ack        (cr_ack),
  .phy_dout   (cr_dout),
  .result_q   (result_q),
  .sts_err    (sts_err),
  .tmo_evt    (tmo_evt)
);

// File: tb/phycr_bridge_test.sv
module phycr_bridge_test;

  localparam int WD = 16;
  localparam logic [7:0] A_STAGE = 8'h3C, A_RES = 8'h40, A_CAPA = 8'h44,
                         A_CAPD = 8'h48, A_RD = 8'h4C, A_WR = 8'h50, A_STS = 8'h54;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [7:0]  host_addr = 8'h00;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [15:0] cr_din;
  logic [15:0] cr_dout = '0;
  logic        cr_cap_addr_stb, cr_cap_data_stb, cr_rd_stb, cr_wr_stb;
  logic        cr_cap_addr_ack = 1'b0, cr_cap_data_ack = 1'b0;
  logic        cr_rd_ack = 1'b0, cr_wr_ack = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  phycr_bridge #(.WD_CYCLES(WD)) uut (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cr_din(cr_din),
    .cr_dout(cr_dout), .cr_cap_addr_stb(cr_cap_addr_stb),
    .cr_cap_data_stb(cr_cap_data_stb), .cr_rd_stb(cr_rd_stb), .cr_wr_stb(cr_wr_stb),
    .cr_cap_addr_ack(cr_cap_addr_ack), .cr_cap_data_ack(cr_cap_data_ack),
    .cr_rd_ack(cr_rd_ack), .cr_wr_ack(cr_wr_ack)
  );

  logic [3:0] stbv;
  assign stbv = {cr_wr_stb, cr_rd_stb, cr_cap_data_stb, cr_cap_addr_stb};

  // ---------------- PHY responder model ----------------
  int          lat = 0;
  bit          mute = 1'b0;
  int          wcnt = 0;
  logic [15:0] lat_addr = '0, lat_data = '0;
  logic [15:0] mem [logic [15:0]];

  always @(posedge clk) begin
    cr_cap_addr_ack <= 1'b0;
    cr_cap_data_ack <= 1'b0;
    cr_rd_ack       <= 1'b0;
    cr_wr_ack       <= 1'b0;
    if (stbv != 4'b0 && !mute &&
        !(cr_cap_addr_ack | cr_cap_data_ack | cr_rd_ack | cr_wr_ack)) begin
      if (wcnt == lat) begin
        wcnt <= 0;
        if (cr_cap_addr_stb) begin lat_addr <= cr_din; cr_cap_addr_ack <= 1'b1; end
        if (cr_cap_data_stb) begin lat_data <= cr_din; cr_cap_data_ack <= 1'b1; end
        if (cr_wr_stb) begin mem[lat_addr] = lat_data; cr_wr_ack <= 1'b1; end
        if (cr_rd_stb) begin
          cr_dout   <= mem.exists(lat_addr) ? mem[lat_addr] : 16'h0000;
          cr_rd_ack <= 1'b1;
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end else begin
      wcnt <= 0;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard: driver pushes expectations, monitor pops on each tagged read.
  logic [31:0] exp_q[$];
  string       req_q[$];
  bit          mon_req = 1'b0;

  always @(negedge clk) begin
    if (mon_req && exp_q.size() > 0) begin
      automatic logic [31:0] e = exp_q.pop_front();
      automatic string r = req_q.pop_front();
      chk(r, host_rdata, e);
    end
  end

  bit wr_seen = 1'b0;
  always @(negedge clk) if (cr_wr_stb) wr_seen = 1'b1;

  task automatic host_wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    host_addr = a; host_wdata = d; host_wr_en = 1'b1;
    @(posedge clk); #1;
    host_wr_en = 1'b0;
  endtask

  task automatic expect_rd(logic [7:0] a, logic [31:0] e, string req);
    @(posedge clk); #1;
    host_addr = a;
    exp_q.push_back(e);
    req_q.push_back(req);
    mon_req = 1'b1;
    @(posedge clk); #1;
    mon_req = 1'b0;
  endtask

  task automatic peek(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic poll(logic [7:0] a, string req);
    logic [31:0] d;
    for (int i = 0; i < 200; i++) begin
      peek(a, d);
      if (d == 32'h0) return;
    end
    chk(req, d, 32'h0);
  endtask

  task automatic measure(logic [7:0] a, output int n);
    host_wr(a, 32'h1);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (stbv != 4'b0) n++;
      else break;
    end
  endtask

  task automatic phy_write(logic [15:0] a, logic [15:0] v);
    host_wr(A_STAGE, {16'h0, a}); host_wr(A_CAPA, 1); poll(A_CAPA, "R10");
    host_wr(A_STAGE, {16'h0, v}); host_wr(A_CAPD, 1); poll(A_CAPD, "R10");
    host_wr(A_WR, 1); poll(A_WR, "R10");
  endtask

  task automatic phy_read(logic [15:0] a, logic [15:0] e, string req);
    host_wr(A_STAGE, {16'h0, a}); host_wr(A_CAPA, 1); poll(A_CAPA, req);
    host_wr(A_RD, 1); poll(A_RD, req);
    expect_rd(A_RES, {16'h0, e}, req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    @(negedge clk); chk("R1 strobes", {28'h0, stbv}, 32'h0);
    expect_rd(A_CAPA, 0, "R1 capa");
    expect_rd(A_CAPD, 0, "R1 capd");
    expect_rd(A_RD,   0, "R1 rd");
    expect_rd(A_WR,   0, "R1 wr");
    expect_rd(A_RES,  0, "R1 result");
    expect_rd(A_STS,  0, "R1 status");

    // R2 / R3 staging register and PHY data bus
    host_wr(A_STAGE, 32'hDEAD_1006);
    expect_rd(A_STAGE, 32'hDEAD_1006, "R2 staging readback");
    @(negedge clk); chk("R3 cr_din", {16'h0, cr_din}, 32'h0000_1006);
    expect_rd(8'h00, 0, "R2 unmapped");

    // R4 bit0=0 starts nothing, bit0=1 starts the strobe next cycle
    lat = 3;
    host_wr(A_CAPA, 32'hFFFF_FFFE);
    @(negedge clk); chk("R4 zero write", {28'h0, stbv}, 32'h0);
    expect_rd(A_CAPA, 0, "R4 zero write readback");
    host_wr(A_CAPA, 1);
    @(negedge clk); chk("R4 strobe", {28'h0, stbv}, 32'h1);
    expect_rd(A_CAPA, 1, "R4 busy readback");
    poll(A_CAPA, "R6");

    // R5 / R6 strobe length = lat + 2
    measure(A_CAPD, n);
    chk("R5 R6 strobe length lat3", n, 5);
    expect_rd(A_CAPD, 0, "R6 cleared");
    lat = 0;
    measure(A_CAPA, n);
    chk("R6 strobe length lat0", n, 2);

    // R10 write / read round trip, lanes 0x100 apart
    lat = 1;
    phy_write(16'h1006, 16'hABCD);
    lat = 0;
    phy_write(16'h1106, 16'h1234);
    phy_read(16'h1006, 16'hABCD, "R10 lane0");
    phy_read(16'h1106, 16'h1234, "R10 lane1");

    // R7 result holds
    host_wr(A_RES, 32'h0000_FFFF);
    expect_rd(A_RES, 32'h1234, "R7 write ignored");
    phy_write(16'h1006, 16'h5555);
    expect_rd(A_RES, 32'h1234, "R7 held across write op");

    // R8 collision
    lat = 4;
    host_wr(A_STAGE, 32'h1006); host_wr(A_CAPA, 1); poll(A_CAPA, "R8");
    wr_seen = 1'b0;
    host_wr(A_RD, 1);
    host_wr(A_WR, 1);
    poll(A_RD, "R8");
    chk("R8 no write strobe", {31'h0, wr_seen}, 32'h0);
    expect_rd(A_RES, 32'h5555, "R8 read unaffected");
    expect_rd(A_STS, 32'h1, "R8 sticky set");
    lat = 0;
    phy_read(16'h1106, 16'h1234, "R8 later read");
    expect_rd(A_STS, 32'h1, "R8 still sticky");
    host_wr(A_STS, 32'h1);
    expect_rd(A_STS, 32'h0, "R8 cleared by W1C");

    // R9 watchdog
    mute = 1'b1;
    host_wr(A_STAGE, 32'h1006);
    measure(A_RD, n);
    chk("R9 timeout length", n, WD);
    expect_rd(A_RD, 0, "R9 trigger cleared");
    expect_rd(A_STS, 32'h2, "R9 timeout flag");
    expect_rd(A_RES, 32'h1234, "R9 result unchanged");
    mute = 1'b0;
    phy_read(16'h1006, 16'h5555, "R9 recovery");
    expect_rd(A_STS, 32'h2, "R9 flag sticky");
    host_wr(A_STS, 32'h2);
    expect_rd(A_STS, 32'h0, "R9 cleared by W1C");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule